// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block buffers 18-bit words between two free-running clocks that may be unrelated or identical. A producer in the write-clock domain pushes words while its ready flag is high; a consumer in the read-clock domain sees each word appear in an output register, with its own ready flag, before it asks for it. Pointers cross between the domains as Gray codes through two-flop synchronizers.

Total capacity is 64 words, counting the word held in the output register. The first word written into an empty FIFO moves into that register on its own. A consumer takes a word only when its read enable and both output-enable inputs are low together. The write side also reports a half-full level and an almost-full/almost-empty level whose window width is set through the write port. The reset input is asynchronous and must be held for at least four rising edges of each clock.

Top module: `dcf_fifo_fwft`

## Requirements
- R1: The FIFO holds at most 64 words of 18 bits, including the word in the output register. `in_rdy` is low whenever 64 words are held.
- R2: A word is stored on a rising `wr_clk` edge only when `wr_en_hi` is 1, `wr_en_lo_n` is 0, `prog_en` is 0 and `in_rdy` is 1.
- R3: A word leaves the output register on a rising `rd_clk` edge only when `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_rdy` is 1.
- R4: When the FIFO has been empty, the next stored word reaches `rd_data` and raises `out_rdy` with all read controls inactive.
- R5: While `out_rdy` is 1 and no read takes place, `rd_data` and `out_rdy` hold. `out_rdy` falls after the last word is taken.
- R6: A write attempt while `in_rdy` is 0 and a read attempt while `out_rdy` is 0 change neither the stored words nor their order.
- R7: While `rst` is 1, `in_rdy`, `out_rdy` and `half_full` are 0 and `alm_flag` is 1. Right after release `in_rdy` is still 0. It rises within a few write-clock edges.
- R8: `half_full` is 1 exactly when the write side counts 33 or more held words.
- R9: `alm_flag` is 1 exactly when the held count C satisfies C <= N or C >= 64 - N. N is 8 after every reset.
- R10: A rising `wr_clk` edge with `prog_en` at 1 loads N from `wr_data[5:0]` and stores no word.
- R11: Words leave in the order they were stored, with their data intact, when the two clocks run at unrelated rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous reset, active high |
| wr_clk | input | 1 | Write clock |
| wr_en_hi | input | 1 | Write enable, active high |
| wr_en_lo_n | input | 1 | Write enable, active low |
| prog_en | input | 1 | Load the almost-level window from wr_data[5:0] |
| wr_data | input | 18 | Word to store |
| in_rdy | output | 1 | Room for a word (write domain) |
| rd_clk | input | 1 | Read clock |
| rd_en_n | input | 1 | Read enable, active low |
| oe_a_n | input | 1 | First output enable, active low |
| oe_b_n | input | 1 | Second output enable, active low |
| rd_data | output | 18 | Output register contents |
| out_rdy | output | 1 | Output register holds a valid word (read domain) |
| half_full | output | 1 | 33 or more words held (write domain) |
| alm_flag | output | 1 | Held count within N of empty or of full (write domain) |

## Verification
The bench drives each output-enable input high on its own while the other read controls are low. A design that ignored either enable would lose a word. It also writes with each wrong combination of the two write enables, where a polarity mistake would store an extra word that shows up when the FIFO is drained. The FIFO is filled past 64 words and read past empty, and the order is checked against a queue. Mishandled pointer arithmetic at the wrap or at full would repeat, drop or overwrite words. `half_full` and `alm_flag` are compared at every count from 1 to 64 with the reset window and with a loaded window. This catches off-by-one thresholds, a count that leaves out the output register, a programming write that also stores a word, and a window that survives reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    // Depth of the local reset release pipeline in each clock domain
    localparam int RST_PIPE = 2;
    typedef logic [RST_PIPE-1:0] rst_pipe_t;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or posedge arst) begin
                if (arst) stg_q[g] <= '0;
                else      stg_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or posedge arst) begin
                if (arst) stg_q[g] <= '0;
                else      stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int AW      = 6,
    parameter int DEF_OFS = 8
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          en_hi,
    input  logic          en_lo_n,
    input  logic          prog_en,
    input  logic [AW-1:0] ofs_in,
    input  logic [AW:0]   cgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          in_rdy,
    output logic          half_full,
    output logic          alm_flag,
    output logic [AW:0]   cnt
);
    localparam int            DEPTH   = 1 << AW;
    localparam logic [AW:0]   DEPTH_V = (AW+1)'(DEPTH);
    localparam logic [AW:0]   HALF_V  = (AW+1)'(DEPTH / 2 + 1);
    localparam logic [AW-1:0] OFS_RST = AW'(DEF_OFS);

    typedef struct packed {
        rst_pipe_t     rsync;
        logic [AW:0]   wbin;
        logic [AW:0]   wgray;
        logic [AW-1:0] ofs;
        logic          rdy;
    } wr_state_t;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [AW:0] to_bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wr_state_t   st_q, st_d;
    logic        fire_d;
    logic [AW:0] rbin_d;
    logic [AW:0] cnt_d;

    always_comb begin
        rbin_d      = to_bin(cgray_s);
        fire_d      = st_q.rdy & en_hi & ~en_lo_n & ~prog_en;
        st_d        = st_q;
        st_d.rsync  = {st_q.rsync[RST_PIPE-2:0], 1'b1};
        st_d.wbin   = st_q.wbin + (AW+1)'(fire_d);
        st_d.wgray  = to_gray(st_d.wbin);
        if (prog_en) st_d.ofs = ofs_in;
        cnt_d       = st_d.wbin - rbin_d;
        st_d.rdy    = st_q.rsync[RST_PIPE-1] & (cnt_d != DEPTH_V);
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            st_q <= '{rsync: '0, wbin: '0, wgray: '0, ofs: OFS_RST, rdy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign we        = fire_d;
    assign waddr     = st_q.wbin[AW-1:0];
    assign wgray     = st_q.wgray;
    assign in_rdy    = st_q.rdy;
    assign cnt       = st_q.wbin - rbin_d;
    assign half_full = (cnt >= HALF_V);
    assign alm_flag  = (cnt <= {1'b0, st_q.ofs}) | (cnt >= DEPTH_V - {1'b0, st_q.ofs});
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          rd_en_n,
    input  logic          oe_a_n,
    input  logic          oe_b_n,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] ram_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   cgray,
    output logic [DW-1:0] rd_data,
    output logic          out_rdy
);
    typedef struct packed {
        rst_pipe_t     rsync;
        logic [AW:0]   fbin;
        logic [AW:0]   cbin;
        logic [AW:0]   cgray;
        logic [DW-1:0] dout;
        logic          vld;
    } rd_state_t;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [AW:0] to_bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    rd_state_t   st_q, st_d;
    logic [AW:0] wbin_d;
    logic        take_d;
    logic        load_d;

    always_comb begin
        wbin_d     = to_bin(wgray_s);
        take_d     = st_q.vld & ~rd_en_n & ~oe_a_n & ~oe_b_n;
        load_d     = st_q.rsync[RST_PIPE-1] & (st_q.fbin != wbin_d) & (~st_q.vld | take_d);
        st_d       = st_q;
        st_d.rsync = {st_q.rsync[RST_PIPE-2:0], 1'b1};
        st_d.fbin  = st_q.fbin + (AW+1)'(load_d);
        st_d.cbin  = st_q.cbin + (AW+1)'(take_d);
        st_d.cgray = to_gray(st_d.cbin);
        if (load_d) st_d.dout = ram_q;
        st_d.vld   = load_d | (st_q.vld & ~take_d);
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign raddr   = st_q.fbin[AW-1:0];
    assign cgray   = st_q.cgray;
    assign rd_data = st_q.dout;
    assign out_rdy = st_q.vld;
endmodule

// File: rtl/dcf_fifo_fwft.sv
module dcf_fifo_fwft #(
    parameter int DW          = 18,
    parameter int AW          = 6,
    parameter int DEF_OFS     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          rst,
    input  logic          wr_clk,
    input  logic          wr_en_hi,
    input  logic          wr_en_lo_n,
    input  logic          prog_en,
    input  logic [DW-1:0] wr_data,
    output logic          in_rdy,
    input  logic          rd_clk,
    input  logic          rd_en_n,
    input  logic          oe_a_n,
    input  logic          oe_b_n,
    output logic [DW-1:0] rd_data,
    output logic          out_rdy,
    output logic          half_full,
    output logic          alm_flag
);
    logic          wr_we;
    logic [AW-1:0] wr_addr;
    logic [AW:0]   wgray, wgray_s;
    logic [AW:0]   cgray, cgray_s;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] ram_q;
    logic [AW:0]   wr_cnt;

    dcf_wr_ctl #(.AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
        .clk       (wr_clk),
        .arst      (rst),
        .en_hi     (wr_en_hi),
        .en_lo_n   (wr_en_lo_n),
        .prog_en   (prog_en),
        .ofs_in    (wr_data[AW-1:0]),
        .cgray_s   (cgray_s),
        .we        (wr_we),
        .waddr     (wr_addr),
        .wgray     (wgray),
        .in_rdy    (in_rdy),
        .half_full (half_full),
        .alm_flag  (alm_flag),
        .cnt       (wr_cnt)
    );

    dcf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk  (wr_clk),
        .we    (wr_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (ram_q)
    );

    dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
        .clk  (rd_clk),
        .arst (rst),
        .d    (wgray),
        .q    (wgray_s)
    );

    dcf_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
        .clk  (wr_clk),
        .arst (rst),
        .d    (cgray),
        .q    (cgray_s)
    );

    dcf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
        .clk     (rd_clk),
        .arst    (rst),
        .rd_en_n (rd_en_n),
        .oe_a_n  (oe_a_n),
        .oe_b_n  (oe_b_n),
        .wgray_s (wgray_s),
        .ram_q   (ram_q),
        .raddr   (rd_addr),
        .cgray   (cgray),
        .rd_data (rd_data),
        .out_rdy (out_rdy)
    );
endmodule

// File: rtl/dcf_fifo_fwft_chk.sv
module dcf_fifo_fwft_chk #(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst,
    input logic          in_rdy,
    input logic          out_rdy,
    input logic          half_full,
    input logic          alm_flag,
    input logic          rd_en_n,
    input logic          oe_a_n,
    input logic          oe_b_n,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   wr_cnt
);
    localparam logic [AW:0] FULL_V  = (AW+1)'(1 << AW);
    localparam logic [AW:0] BELOW_H = (AW+1)'(1 << (AW - 1));

    // R1
    wr_cap_chk: assert property (@(posedge wr_clk) disable iff (rst)
        wr_cnt <= FULL_V);

    // R1
    rdy_room_chk: assert property (@(posedge wr_clk) disable iff (rst)
        in_rdy |-> wr_cnt < FULL_V);

    // R6
    blocked_write_chk: assert property (@(posedge wr_clk) disable iff (rst)
        !in_rdy |=> wr_cnt <= $past(wr_cnt));

    // R5
    out_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
        (out_rdy && (rd_en_n || oe_a_n || oe_b_n)) |=> (out_rdy && $stable(rd_data)));

    // R8
    half_rise_chk: assert property (@(posedge wr_clk) disable iff (rst)
        $rose(half_full) |-> $past(wr_cnt) == BELOW_H);

    // R7
    always @(posedge wr_clk) begin
        if (rst) begin
            reset_wr_flags_chk: assert (!in_rdy && !half_full && alm_flag);
        end
    end

    // R7
    always @(posedge rd_clk) begin
        if (rst) begin
            reset_rd_flag_chk: assert (!out_rdy);
        end
    end
endmodule

bind dcf_fifo_fwft dcf_fifo_fwft_chk #(.DW(DW), .AW(AW)) chk_i (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst       (rst),
    .in_rdy    (in_rdy),
    .out_rdy   (out_rdy),
    .half_full (half_full),
    .alm_flag  (alm_flag),
    .rd_en_n   (rd_en_n),
    .oe_a_n    (oe_a_n),
    .oe_b_n    (oe_b_n),
    .rd_data   (rd_data),
    .wr_cnt    (wr_cnt)
);

// File: tb/dcf_fifo_fwft_tb_top.sv
module dcf_fifo_fwft_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 18;
    localparam int DEPTH = 64;

    logic          rst = 1'b1;
    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_en_hi = 1'b0;
    logic          wr_en_lo_n = 1'b1;
    logic          prog_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          oe_a_n = 1'b1;
    logic          oe_b_n = 1'b1;
    logic          in_rdy, out_rdy, half_full, alm_flag;
    logic [DW-1:0] rd_data;

    logic [DW-1:0] model [$];
    int n_cmp = 0;
    int n_bad = 0;
    bit wr_done = 1'b0;

    always #4   wr_clk = ~wr_clk;
    always #6.5 rd_clk = ~rd_clk;

    dcf_fifo_fwft dut_i (
        .rst(rst), .wr_clk(wr_clk), .wr_en_hi(wr_en_hi), .wr_en_lo_n(wr_en_lo_n),
        .prog_en(prog_en), .wr_data(wr_data), .in_rdy(in_rdy),
        .rd_clk(rd_clk), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .rd_data(rd_data), .out_rdy(out_rdy), .half_full(half_full), .alm_flag(alm_flag)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_word(input logic [DW-1:0] d, input logic hi, input logic lon,
                           input logic prg, output bit acc);
        @(negedge wr_clk);
        wr_data = d; wr_en_hi = hi; wr_en_lo_n = lon; prog_en = prg;
        acc = in_rdy && hi && !lon && !prg;
        if (acc) model.push_back(d);
    endtask

    task automatic wr_idle();
        @(negedge wr_clk);
        wr_en_hi = 1'b0; wr_en_lo_n = 1'b1; prog_en = 1'b0;
    endtask

    task automatic rd_step(input logic rdn, input logic oa, input logic ob);
        logic [DW-1:0] exp;
        @(negedge rd_clk);
        rd_en_n = rdn; oe_a_n = oa; oe_b_n = ob;
        if (out_rdy && !rdn && !oa && !ob) begin
            if (model.size() == 0) begin
                chk("R6", "word present with none stored", {14'd0, rd_data}, 32'hFFFF_FFFF);
            end else begin
                exp = model.pop_front();
                chk("R11", "read data", {14'd0, rd_data}, {14'd0, exp});
            end
        end
    endtask

    task automatic rd_idle();
        @(negedge rd_clk);
        rd_en_n = 1'b1; oe_a_n = 1'b1; oe_b_n = 1'b1;
    endtask

    task automatic drain();
        int guard = 0;
        while (model.size() > 0 && guard < 4000) begin
            rd_step(1'b0, 1'b0, 1'b0);
            guard++;
        end
        chk("R11", "words left after drain", model.size(), 0);
        repeat (16) rd_step(1'b0, 1'b0, 1'b0);
        chk("R5", "out_rdy after last word", {31'd0, out_rdy}, 0);
        rd_idle();
    endtask

    task automatic t_reset();
        @(negedge wr_clk);
        rst = 1'b1;
        wr_en_hi = 1'b0; wr_en_lo_n = 1'b1; prog_en = 1'b0;
        rd_en_n = 1'b1; oe_a_n = 1'b1; oe_b_n = 1'b1;
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        model.delete();
        @(negedge wr_clk);
        chk("R7", "in_rdy in reset", {31'd0, in_rdy}, 0);
        chk("R7", "out_rdy in reset", {31'd0, out_rdy}, 0);
        chk("R7", "half_full in reset", {31'd0, half_full}, 0);
        chk("R7", "alm_flag in reset", {31'd0, alm_flag}, 1);
        rst = 1'b0;
        chk("R7", "in_rdy at release", {31'd0, in_rdy}, 0);
        repeat (8) @(negedge wr_clk);
        chk("R7", "in_rdy after release", {31'd0, in_rdy}, 1);
        chk("R7", "alm_flag after release", {31'd0, alm_flag}, 1);
        repeat (4) @(negedge rd_clk);
        chk("R7", "out_rdy after release", {31'd0, out_rdy}, 0);
    endtask

    task automatic t_fwft();
        bit acc;
        wr_word(18'h2A5A5, 1'b1, 1'b0, 1'b0, acc);
        wr_idle();
        repeat (8) @(negedge rd_clk);
        chk("R4", "out_rdy without read", {31'd0, out_rdy}, 1);
        chk("R4", "word fell through", {14'd0, rd_data}, 32'h2A5A5);
        repeat (3) rd_step(1'b0, 1'b1, 1'b0);
        repeat (3) rd_step(1'b0, 1'b0, 1'b1);
        repeat (3) rd_step(1'b1, 1'b0, 1'b0);
        rd_idle();
        chk("R3", "out_rdy held under gating", {31'd0, out_rdy}, 1);
        chk("R3", "data held under gating", {14'd0, rd_data}, 32'h2A5A5);
        drain();
    endtask

    task automatic t_polarity();
        bit acc;
        wr_word(18'h00AAA, 1'b0, 1'b0, 1'b0, acc);
        wr_word(18'h00BBB, 1'b1, 1'b1, 1'b0, acc);
        wr_word(18'h00CCC, 1'b0, 1'b1, 1'b0, acc);
        wr_word(18'h00DDD, 1'b1, 1'b0, 1'b0, acc);
        wr_idle();
        repeat (8) @(negedge rd_clk);
        chk("R2", "only enabled write stored", {14'd0, rd_data}, 32'h00DDD);
        drain();
    endtask

    task automatic t_empty_read();
        bit acc;
        repeat (6) rd_step(1'b0, 1'b0, 1'b0);
        chk("R6", "out_rdy after empty reads", {31'd0, out_rdy}, 0);
        rd_idle();
        wr_word(18'h1E1E1, 1'b1, 1'b0, 1'b0, acc);
        wr_idle();
        repeat (8) @(negedge rd_clk);
        chk("R6", "word after empty reads", {14'd0, rd_data}, 32'h1E1E1);
        drain();
    endtask

    task automatic t_fill(input int n, input string alm_req);
        bit acc;
        int sz;
        for (int k = 0; k < DEPTH + 4; k++) begin
            wr_word(18'(k * 1237 + 5), 1'b1, 1'b0, 1'b0, acc);
            wr_idle();
            sz = model.size();
            chk("R8", $sformatf("half_full at %0d", sz), {31'd0, half_full}, {31'd0, sz >= 33});
            chk(alm_req, $sformatf("alm_flag at %0d", sz), {31'd0, alm_flag},
                {31'd0, (sz <= n) || (sz >= DEPTH - n)});
        end
        chk("R1", "words accepted", model.size(), DEPTH);
        chk("R1", "in_rdy when full", {31'd0, in_rdy}, 0);
        drain();
        repeat (10) @(negedge wr_clk);
        chk("R8", "half_full after drain", {31'd0, half_full}, 0);
        chk(alm_req, "alm_flag after drain", {31'd0, alm_flag}, 1);
        chk("R1", "in_rdy after drain", {31'd0, in_rdy}, 1);
    endtask

    task automatic t_prog();
        bit acc;
        wr_word(18'h3FF04, 1'b1, 1'b0, 1'b1, acc);
        wr_idle();
        t_fill(4, "R10");
    endtask

    task automatic t_stream();
        wr_done = 1'b0;
        fork
            begin
                int got = 0;
                int k = 0;
                bit acc;
                while (got < 300) begin
                    if (k % 4 == 3) begin
                        wr_idle();
                    end else begin
                        wr_word(18'((k * 7919) ^ (k << 5)), 1'b1, 1'b0, 1'b0, acc);
                        if (acc) got++;
                    end
                    k++;
                end
                wr_idle();
                wr_done = 1'b1;
            end
            begin
                int k = 0;
                while ((!wr_done || model.size() > 0) && k < 20000) begin
                    rd_step(k % 5 == 3, k % 7 == 2, k % 11 == 6);
                    k++;
                end
                rd_idle();
            end
        join
        chk("R11", "stream words left", model.size(), 0);
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fwft();
        t_polarity();
        t_empty_read();
        t_prog();
        t_reset();
        t_fill(8, "R9");
        t_stream();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule